// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block decides where each host memory access below 1 MB is sent. Every access falls into one of three routes: a read served by DRAM, a write served by DRAM, or a forward to the PCI side. The decision is purely combinational from the access address, its direction and the processor's system-management-mode flag. It also depends on eight configuration bytes held inside the block. A byte-wide configuration write port updates those bytes. The new routing takes effect on the access presented in the cycle after the write edge.

The legacy hole from 0xA0000 to 0xFFFFF contains three kinds of space. The first is a 128 KB SMRAM window at 0xA0000. The second is twelve 16 KB expansion regions from 0xC0000 to 0xEFFFF. The third is one 64 KB BIOS region at 0xF0000. Seven attribute bytes hold the read and write enables for the thirteen attribute regions. The BIOS region has a byte of its own, and each pair of expansion regions shares one byte, one nibble each. A separate SMRAM control byte opens the SMRAM window to DRAM, either always or only while system-management mode is active. Everything outside the hole goes to DRAM.

Top module: `lmr_decoder`

## Requirements
- R1: After reset all seven attribute bytes are 0x00 and the SMRAM control byte is 0x02. Therefore every access in 0xA0000–0xFFFFF is forwarded to PCI, whatever the mode flag.
- R2: An access outside 0xA0000–0xFFFFF (in particular 0x00000–0x9FFFF) always goes to DRAM: a read raises `dram_rd_sel` and a write raises `dram_wr_sel`.
- R3: Exactly one of `dram_rd_sel`, `dram_wr_sel` and `pci_sel` is high at all times. `dram_rd_sel` is never high for a write, and `dram_wr_sel` is never high for a read.
- R4: The BIOS region 0xF0000–0xFFFFF takes its enables from the upper nibble of configuration byte 0x59: bit 4 enables reads and bit 5 enables writes. The lower nibble of 0x59 has no effect on it.
- R5: Expansion region e (e = 0..11, base 0xC0000 + e·0x4000, 16 KB) takes its enables from byte 0x5A + e/2. Even e uses the low nibble and odd e the high nibble. Within a nibble, bit 0 enables reads and bit 1 enables writes.
- R6: Within an attribute region, a read whose read enable is clear and a write whose write enable is clear are forwarded to PCI. The two enables act independently.
- R7: An access in the SMRAM window 0xA0000–0xBFFFF goes to DRAM when bit 6 (open) of byte 0x72 is set. It also goes to DRAM when `smm_active` is high and bit 3 (enable) of byte 0x72 is set. Otherwise it is forwarded to PCI, and no attribute byte affects it.
- R8: A configuration write to any offset other than 0x59–0x5F and 0x72 has no effect on any routing decision.
- R9: A configuration write changes only the addressed byte. The routing for an access reflects the new value from the cycle after the write's clock edge, and still reflects the old value before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration bytes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte write data |
| acc_addr | input | ADDR_W (20) | Host memory access address |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| smm_active | input | 1 | Processor is in system-management mode |
| dram_rd_sel | output | 1 | Access is a read served by DRAM |
| dram_wr_sel | output | 1 | Access is a write served by DRAM |
| pci_sel | output | 1 | Access is forwarded to PCI |

## Verification
The assertions check several properties on every cycle. The three selects are one-hot and agree with the access direction. Addresses outside the legacy hole never reach PCI. A closed SMRAM window always forwards to PCI. A BIOS-region DRAM read or write has its matching enable bit set. A write to an unrelated offset leaves the outputs unchanged while the access inputs hold still. Other points need the bench's directed scenarios, because they depend on which configuration byte and nibble governs which address: the nibble pairing across all twelve expansion regions, the independence of the read and write enables, the reset values, and the exact edge at which a new byte takes over.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
   // nibble layout of one attribute region
   localparam int unsigned NIB_RD_BIT   = 0;
   localparam int unsigned NIB_WR_BIT   = 1;
   // SMRAM control byte fields
   localparam int unsigned SMR_EN_BIT   = 3;
   localparam int unsigned SMR_OPEN_BIT = 6;

   typedef struct packed {
      logic rd_en;
      logic wr_en;
   } lmr_perm_t;

   typedef enum logic [1:0] {
      ROUTE_PCI     = 2'd0,
      ROUTE_DRAM_RD = 2'd1,
      ROUTE_DRAM_WR = 2'd2
   } lmr_route_e;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs #(
   parameter logic [7:0] ATTR_BASE  = 8'h59,
   parameter int unsigned ATTR_BYTES = 7,
   parameter logic [7:0] SMR_OFS    = 8'h72,
   parameter logic [7:0] SMR_RST    = 8'h02
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic [7:0]                 cfg_addr,
   input  logic [7:0]                 cfg_wdata,
   output logic [ATTR_BYTES-1:0][7:0] attr_q,
   output logic [7:0]                 smram_q
);
   for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
      localparam logic [7:0] OFS = 8'(int'(ATTR_BASE) + b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            attr_q[b] <= 8'h00;
         else if (cfg_we && cfg_addr == OFS)
            attr_q[b] <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         smram_q <= SMR_RST;
      else if (cfg_we && cfg_addr == SMR_OFS)
         smram_q <= cfg_wdata;
   end
endmodule

// File: rtl/lmr_region_hit.sv
module lmr_region_hit
   import lmr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 20,
   parameter int unsigned ATTR_BYTES  = 7,
   parameter int unsigned NUM_REG     = 13,
   parameter logic [19:0] BIOS_BASE   = 20'hF0000,
   parameter int unsigned BIOS_LG     = 16,
   parameter logic [19:0] EXP_BASE    = 20'hC0000,
   parameter int unsigned EXP_LG      = 14,
   parameter logic [19:0] SMR_BASE    = 20'hA0000,
   parameter int unsigned SMR_LG      = 17
) (
   input  logic [ADDR_W-1:0]          addr,
   input  logic [ATTR_BYTES-1:0][7:0] attr_q,
   output logic                       attr_hit,
   output lmr_perm_t                  perm,
   output logic                       smr_hit
);
   logic [NUM_REG-1:0] hit_v;
   logic [NUM_REG-1:0] rd_v;
   logic [NUM_REG-1:0] wr_v;

   for (genvar i = 0; i < NUM_REG; i++) begin : g_reg
      localparam int unsigned LG = (i == 0) ? BIOS_LG : EXP_LG;
      localparam logic [ADDR_W-1:0] BASE = (i == 0) ?
         ADDR_W'(BIOS_BASE) :
         ADDR_W'(EXP_BASE) + ADDR_W'((i - 1) * (1 << EXP_LG));
      localparam int unsigned BYTE_IX = (i + 1) / 2;
      // region 0 and every even region use the upper nibble
      localparam bit HI_NIB = (i % 2) == 0;
      logic [3:0] nib;
      if (HI_NIB) begin : g_hi
         assign nib = attr_q[BYTE_IX][7:4];
      end else begin : g_lo
         assign nib = attr_q[BYTE_IX][3:0];
      end
      assign hit_v[i] = addr[ADDR_W-1:LG] == BASE[ADDR_W-1:LG];
      assign rd_v[i]  = hit_v[i] & nib[NIB_RD_BIT];
      assign wr_v[i]  = hit_v[i] & nib[NIB_WR_BIT];
   end

   localparam logic [ADDR_W-1:0] SMR_B = ADDR_W'(SMR_BASE);

   assign attr_hit   = |hit_v;
   assign perm.rd_en = |rd_v;
   assign perm.wr_en = |wr_v;
   assign smr_hit    = addr[ADDR_W-1:SMR_LG] == SMR_B[ADDR_W-1:SMR_LG];
endmodule

// File: rtl/lmr_route_sel.sv
module lmr_route_sel
   import lmr_pkg::*;
(
   input  logic       acc_write,
   input  logic       smm_active,
   input  logic       attr_hit,
   input  lmr_perm_t  perm,
   input  logic       smr_hit,
   input  logic [7:0] smram_q,
   output lmr_route_e route
);
   logic smr_dram;
   logic to_dram;

   assign smr_dram = smram_q[SMR_OPEN_BIT] | (smm_active & smram_q[SMR_EN_BIT]);

   always_comb begin
      if (smr_hit)
         to_dram = smr_dram;
      else if (attr_hit)
         to_dram = acc_write ? perm.wr_en : perm.rd_en;
      else
         to_dram = 1'b1;

      if (!to_dram)
         route = ROUTE_PCI;
      else if (acc_write)
         route = ROUTE_DRAM_WR;
      else
         route = ROUTE_DRAM_RD;
   end
endmodule

// File: rtl/lmr_decoder.sv
module lmr_decoder
   import lmr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 20,
   parameter logic [7:0]  ATTR_BASE  = 8'h59,
   parameter int unsigned ATTR_BYTES = 7,
   parameter logic [7:0]  SMR_OFS    = 8'h72,
   parameter logic [7:0]  SMR_RST    = 8'h02,
   parameter int unsigned EXP_COUNT  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_addr,
   input  logic [7:0]        cfg_wdata,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              smm_active,
   output logic              dram_rd_sel,
   output logic              dram_wr_sel,
   output logic              pci_sel
);
   localparam int unsigned NUM_REG = EXP_COUNT + 1;
   localparam int unsigned TOP_BYTE = NUM_REG / 2;

   if (ADDR_W < 20) begin : g_bad_width
      $error("lmr_decoder: ADDR_W must cover 1 MB");
   end
   if (TOP_BYTE >= ATTR_BYTES) begin : g_bad_bytes
      $error("lmr_decoder: too few attribute bytes for the region count");
   end
   if (SMR_OFS >= ATTR_BASE && int'(SMR_OFS) < int'(ATTR_BASE) + ATTR_BYTES) begin : g_bad_ofs
      $error("lmr_decoder: SMRAM offset overlaps attribute bytes");
   end

   logic [ATTR_BYTES-1:0][7:0] attr_q;
   logic [7:0]                 smram_q;
   logic                       attr_hit;
   logic                       smr_hit;
   lmr_perm_t                  perm;
   lmr_route_e                 route;

   lmr_cfg_regs #(
      .ATTR_BASE (ATTR_BASE),
      .ATTR_BYTES(ATTR_BYTES),
      .SMR_OFS   (SMR_OFS),
      .SMR_RST   (SMR_RST)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .attr_q   (attr_q),
      .smram_q  (smram_q)
   );

   lmr_region_hit #(
      .ADDR_W    (ADDR_W),
      .ATTR_BYTES(ATTR_BYTES),
      .NUM_REG   (NUM_REG)
   ) i_hit (
      .addr    (acc_addr),
      .attr_q  (attr_q),
      .attr_hit(attr_hit),
      .perm    (perm),
      .smr_hit (smr_hit)
   );

   lmr_route_sel i_sel (
      .acc_write (acc_write),
      .smm_active(smm_active),
      .attr_hit  (attr_hit),
      .perm      (perm),
      .smr_hit   (smr_hit),
      .smram_q   (smram_q),
      .route     (route)
   );

   assign dram_rd_sel = route == ROUTE_DRAM_RD;
   assign dram_wr_sel = route == ROUTE_DRAM_WR;
   assign pci_sel     = route == ROUTE_PCI;
endmodule

// File: rtl/lmr_decoder_chk.sv
module lmr_decoder_chk #(
   parameter int unsigned ADDR_W    = 20,
   parameter logic [7:0]  ATTR_BASE = 8'h59,
   parameter logic [7:0]  SMR_OFS   = 8'h72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [7:0]        cfg_addr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_write,
   input logic              smm_active,
   input logic [7:0]        bios_attr,
   input logic [7:0]        smram_q,
   input logic              dram_rd_sel,
   input logic              dram_wr_sel,
   input logic              pci_sel
);
   localparam logic [ADDR_W-1:0] HOLE_LO = ADDR_W'(20'hA0000);
   localparam logic [ADDR_W-1:0] HOLE_HI = ADDR_W'(20'hFFFFF);
   localparam logic [ADDR_W-1:0] SMR_HI  = ADDR_W'(20'hBFFFF);
   localparam logic [ADDR_W-1:0] BIOS_LO = ADDR_W'(20'hF0000);

   logic in_hole, in_smr, in_bios, cfg_other;
   assign in_hole   = acc_addr >= HOLE_LO && acc_addr <= HOLE_HI;
   assign in_smr    = acc_addr >= HOLE_LO && acc_addr <= SMR_HI;
   assign in_bios   = acc_addr >= BIOS_LO && acc_addr <= HOLE_HI;
   assign cfg_other = cfg_we && cfg_addr != SMR_OFS &&
                      !(cfg_addr >= ATTR_BASE && cfg_addr <= ATTR_BASE + 8'd6);

   a_r3_onehot_route: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dram_rd_sel, dram_wr_sel, pci_sel}) == 1);

   a_r3_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_rd_sel |-> !acc_write) and (dram_wr_sel |-> acc_write));

   a_r2_outside_dram: assert property (@(posedge clk) disable iff (!rst_n)
      !in_hole |-> !pci_sel);

   a_r7_smram_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (in_smr && !smram_q[6] && !(smm_active && smram_q[3])) |-> pci_sel);

   a_r4_bios_enables: assert property (@(posedge clk) disable iff (!rst_n)
      in_bios |-> ((!dram_rd_sel || bios_attr[4]) && (!dram_wr_sel || bios_attr[5])));

   a_r8_other_write: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_other) && $stable(acc_addr) && $stable(acc_write) && $stable(smm_active))
      |-> ($stable(dram_rd_sel) && $stable(dram_wr_sel) && $stable(pci_sel)));
endmodule

bind lmr_decoder lmr_decoder_chk #(
   .ADDR_W   (ADDR_W),
   .ATTR_BASE(ATTR_BASE),
   .SMR_OFS  (SMR_OFS)
) i_lmr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_addr   (cfg_addr),
   .acc_addr   (acc_addr),
   .acc_write  (acc_write),
   .smm_active (smm_active),
   .bios_attr  (attr_q[0]),
   .smram_q    (smram_q),
   .dram_rd_sel(dram_rd_sel),
   .dram_wr_sel(dram_wr_sel),
   .pci_sel    (pci_sel)
);

// File: tb/test_lmr_decoder.sv
`timescale 1ns/1ps
module test_lmr_decoder;
   localparam int PCI = 0, RD = 1, WR = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [19:0] acc_addr = 20'h0;
   logic        acc_write = 1'b0;
   logic        smm_active = 1'b0;
   logic        dram_rd_sel, dram_wr_sel, pci_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lmr_decoder i_lmr_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
      .smm_active(smm_active), .dram_rd_sel(dram_rd_sel),
      .dram_wr_sel(dram_wr_sel), .pci_sel(pci_sel));

   function automatic logic [2:0] enc(int r);
      return (r == RD) ? 3'b100 : (r == WR) ? 3'b010 : 3'b001;
   endfunction

   task automatic compare(string req, int exp);
      logic [2:0] got;
      got = {dram_rd_sel, dram_wr_sel, pci_sel};
      checks++;
      if (got !== enc(exp)) begin
         errors++;
         $display("FAIL %s addr=%h wr=%0b smm=%0b got rd/wr/pci=%b expected %b",
                  req, acc_addr, acc_write, smm_active, got, enc(exp));
      end
   endtask

   task automatic probe(string req, logic [19:0] a, logic w, logic s, int exp);
      @(negedge clk);
      acc_addr = a; acc_write = w; smm_active = s;
      #1;
      compare(req, exp);
   endtask

   task automatic cfg_write(logic [7:0] ofs, logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_attrs();
      for (int b = 0; b < 7; b++) cfg_write(8'h59 + 8'(b), 8'h00);
   endtask

   task automatic t_reset();
      probe("R1", 20'hC0000, 1'b0, 1'b0, PCI);
      probe("R1", 20'hEFFFF, 1'b1, 1'b0, PCI);
      probe("R1", 20'hF0000, 1'b0, 1'b1, PCI);
      probe("R1", 20'hFFFFF, 1'b1, 1'b0, PCI);
      probe("R1", 20'hA0000, 1'b0, 1'b1, PCI);
      probe("R1", 20'hBFFFF, 1'b1, 1'b1, PCI);
   endtask

   task automatic t_low_dram();
      probe("R2", 20'h00000, 1'b0, 1'b0, RD);
      probe("R2", 20'h12345, 1'b1, 1'b1, WR);
      probe("R2", 20'h9FFFF, 1'b1, 1'b0, WR);
      probe("R3", 20'h9FFFF, 1'b0, 1'b0, RD);
   endtask

   task automatic t_bios();
      cfg_write(8'h59, 8'h03);            // low nibble: must not matter
      probe("R4", 20'hF0000, 1'b0, 1'b0, PCI);
      probe("R4", 20'hF8000, 1'b1, 1'b0, PCI);
      cfg_write(8'h59, 8'h10);
      probe("R4", 20'hF0000, 1'b0, 1'b0, RD);
      probe("R4", 20'hFFFFF, 1'b1, 1'b0, PCI);
      cfg_write(8'h59, 8'h20);
      probe("R4", 20'hFFFFF, 1'b1, 1'b0, WR);
      probe("R4", 20'hF0000, 1'b0, 1'b0, PCI);
      probe("R4", 20'hEFFFF, 1'b0, 1'b0, PCI);
      cfg_write(8'h59, 8'h00);
   endtask

   task automatic t_expansion();
      for (int e = 0; e < 12; e++) begin
         logic [19:0] base;
         logic [7:0]  val;
         logic [19:0] nb;
         base = 20'hC0000 + 20'(e * 20'h4000);
         val  = (e % 2 == 0) ? 8'h03 : 8'h30;
         nb   = 20'hC0000 + 20'((e ^ 1) * 20'h4000);
         cfg_write(8'h5A + 8'(e / 2), val);
         probe("R5", base, 1'b0, 1'b0, RD);
         probe("R5", base + 20'h3FFF, 1'b1, 1'b0, WR);
         probe("R5", nb, 1'b0, 1'b0, PCI);
         cfg_write(8'h5A + 8'(e / 2), 8'h00);
      end
      probe("R5", 20'hF0000, 1'b0, 1'b0, PCI);
   endtask

   task automatic t_rw_split();
      cfg_write(8'h5C, 8'h21);            // e4 read-only, e5 write-only
      probe("R6", 20'hD0000, 1'b0, 1'b0, RD);
      probe("R6", 20'hD0000, 1'b1, 1'b0, PCI);
      probe("R6", 20'hD4000, 1'b1, 1'b0, WR);
      probe("R6", 20'hD7FFF, 1'b0, 1'b0, PCI);
      clear_attrs();
   endtask

   task automatic t_smram();
      for (int b = 0; b < 7; b++) cfg_write(8'h59 + 8'(b), 8'hFF);
      probe("R7", 20'hA0000, 1'b0, 1'b1, PCI);
      cfg_write(8'h72, 8'h08);
      probe("R7", 20'hA0000, 1'b0, 1'b0, PCI);
      probe("R7", 20'hA0000, 1'b0, 1'b1, RD);
      probe("R7", 20'hBFFFF, 1'b1, 1'b1, WR);
      cfg_write(8'h72, 8'h40);
      probe("R7", 20'hB0000, 1'b1, 1'b0, WR);
      probe("R7", 20'hA1234, 1'b0, 1'b0, RD);
      cfg_write(8'h72, 8'h00);
      probe("R7", 20'hA0000, 1'b0, 1'b1, PCI);
      probe("R7", 20'hC0000, 1'b0, 1'b0, RD);
      clear_attrs();
   endtask

   task automatic t_ignored();
      cfg_write(8'h58, 8'hFF);
      cfg_write(8'h60, 8'hFF);
      cfg_write(8'h71, 8'hFF);
      cfg_write(8'h73, 8'hFF);
      probe("R8", 20'hF0000, 1'b0, 1'b0, PCI);
      probe("R8", 20'hC0000, 1'b1, 1'b0, PCI);
      probe("R8", 20'hEC000, 1'b0, 1'b0, PCI);
      probe("R8", 20'hA0000, 1'b0, 1'b1, PCI);
   endtask

   task automatic t_timing();
      @(negedge clk);
      acc_addr = 20'hC0000; acc_write = 1'b0; smm_active = 1'b0;
      cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h03;
      #1;
      compare("R9", PCI);                 // before the edge: old value
      @(negedge clk);
      cfg_we = 1'b0;
      #1;
      compare("R9", RD);                  // after the edge: new value
      probe("R9", 20'hC8000, 1'b0, 1'b0, PCI);
      probe("R9", 20'hC4000, 1'b0, 1'b0, PCI);
      cfg_write(8'h5A, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_low_dram();
      t_bios();
      t_expansion();
      t_rw_split();
      t_smram();
      t_ignored();
      t_timing();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule